// File: doc/BRIEF.md
# Loopback Self-Test Engine for a Four-Lane Retimer

This block is a built-in self-test engine for a multi-lane serial datapath. Software programs a control word with a pattern type and a symbol width, sets the enable bit, and then sets the start bit. From then on the engine sends fixed-length test frames on every lane in parallel. The frames pass through an internal loopback pipeline, and an independent per-lane checker compares each returned symbol against its own copy of the expected sequence.

Each checker counts the frames that arrive and the frames that hold at least one wrong symbol. A transmit frame counter records what was sent. When software asks for a stop, the engine finishes the frame it is sending. It then waits a fixed drain interval so that frames still in the loopback are counted. After that it clears both the stop and start bits, and software reads the counters. A run has passed when no lane shows an error and every lane has received at least one frame.

A loopback corruption input inverts bit 0 of a lane's symbols as they enter the loopback. This stands in for a faulty lane.

Top module: `lbist_engine`

## Requirements
- R1: The control word at address 0 places the pattern type at bits 11:10 (0 deterministic count, 1 and 2 fixed placeholder words, 3 PRBS7), the 10-bit symbol select at bit 12, the enable at bit 13, the stop flag at bit 14 and the start flag at bit 15. Bits 9:0 read as 0, and the whole word reads 0 after reset.
- R2: A control write with bits 13 and 15 both set, made while idle, starts a run. Start then reads 1, and every counter reads 0 from the next cycle. A start write without bit 13 leaves the engine idle.
- R3: A stop (bit 14 written 1 during a run) reads as 1 for at least DRAIN_CYC cycles. When it clears, start also reads 0, while the enable, width and pattern fields keep their values.
- R4: Writing a control word with bit 13 at 0 ends a run at once. Start and stop read 0 from the next cycle, and the transmit frame count stops changing.
- R5: Counter addresses: 1 holds the transmitted frame count, 2+k holds lane k's received frame count, and 2+LANES+k holds lane k's errored frame count. All other addresses read 0.
- R6: After a run with no corruption, every lane's received count equals the nonzero transmitted count and every error count is 0. This holds for every pattern type and for both symbol widths.
- R7: With lane k's corruption input held high, every frame received on lane k counts as errored, and the other lanes show no errors.
- R8: All counters saturate at 2^CNT_W-1 and do not wrap.
- R9: A stop written while idle is ignored, and the stop flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| lpbk_flip | input | LANES | Per-lane loopback corruption: inverts bit 0 of each symbol on that lane |

## Verification
The assertions assume three things. Software changes the control word only through whole-word writes. DRAIN_CYC is larger than the loopback latency plus one checker stage. A run is only started from idle, so counters clear just once per run.

The bench keeps within these limits. It drives writes at falling edges. It waits for the stop flag to drop before reading any counter. It starts a new run only after the previous one has ended or been aborted. It holds each lane's corruption input steady for a whole run, so every frame on that lane is expected to fail.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  localparam int SYM_W = 10;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    PAT_DET   = 2'd0,
    PAT_CRPAT = 2'd1,
    PAT_CJPAT = 2'd2,
    PAT_PRBS  = 2'd3
  } pat_e;

  typedef struct packed {
    pat_e pat;
    logic sym10;
  } run_cfg_t;

  typedef struct packed {
    sym_t st;
    sym_t sym;
  } step_t;

  // Starting state of a lane's sequence; PRBS seeds are never zero
  function automatic sym_t pat_seed(pat_e pat, int lane);
    sym_t s;
    if (pat == PAT_PRBS) s = {3'b000, 7'(lane * 37 + 1)};
    else                 s = sym_t'(lane * 3);
    return s;
  endfunction

  // One symbol step of the pattern: next state and emitted symbol
  function automatic step_t pat_step(pat_e pat, logic sym10, sym_t st);
    step_t      r;
    logic [6:0] lf;
    logic       fb;
    lf    = '0;
    fb    = 1'b0;
    r.st  = st + 1'b1;
    r.sym = st;
    case (pat)
      PAT_DET:   r.sym = st;
      PAT_CRPAT: r.sym = st[0] ? 10'h17C : 10'h283;
      PAT_CJPAT: r.sym = st[1] ? 10'h3E0 : 10'h01F;
      default: begin
        lf = st[6:0];
        for (int i = SYM_W - 1; i >= 0; i--) begin
          fb       = lf[6] ^ lf[5];
          lf       = {lf[5:0], fb};
          r.sym[i] = fb;
        end
        r.st = {3'b000, lf};
      end
    endcase
    if (!sym10) r.sym[9:8] = 2'b00;
    return r;
  endfunction

endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DRAIN_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              tx_idle,
  output logic [15:0]       ctrl_rd,
  output run_cfg_t          run_cfg,
  output run_cfg_t          seed_cfg,
  output logic              gen_en,
  output logic              flush,
  output logic              cnt_clr,
  output logic              busy,
  output logic              stopping
);

  localparam int DRN_W   = $clog2(DRAIN_CYC + 1);
  localparam int B_START = 15;
  localparam int B_STOP  = 14;
  localparam int B_EN    = 13;
  localparam int B_W10   = 12;
  localparam int B_PAT   = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH, ST_DRAIN} state_e;

  state_e     state_q, state_d;
  logic [DRN_W-1:0] drn_q, drn_d;
  pat_e       pat_q, pat_d;
  logic       w10_q, w10_d;
  logic       en_q, en_d;
  run_cfg_t   cfg_q, cfg_d;

  logic wr_ctl, dis_wr, start_ok;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[9:0];

  assign wr_ctl   = reg_wr && (reg_addr == '0);
  assign dis_wr   = wr_ctl && !reg_wdata[B_EN];
  assign start_ok = wr_ctl && reg_wdata[B_EN] && reg_wdata[B_START] && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    drn_d   = drn_q;
    pat_d   = pat_q;
    w10_d   = w10_q;
    en_d    = en_q;
    cfg_d   = cfg_q;
    if (wr_ctl) begin
      pat_d = pat_e'(reg_wdata[B_PAT+1:B_PAT]);
      w10_d = reg_wdata[B_W10];
      en_d  = reg_wdata[B_EN];
    end
    if (dis_wr) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_ok) begin
          state_d = ST_RUN;
          cfg_d   = '{pat: pat_e'(reg_wdata[B_PAT+1:B_PAT]), sym10: reg_wdata[B_W10]};
        end
        ST_RUN: if (wr_ctl && reg_wdata[B_STOP]) state_d = ST_FLUSH;
        ST_FLUSH: if (tx_idle) begin
          state_d = ST_DRAIN;
          drn_d   = '0;
        end
        default: begin
          if (drn_q == DRN_W'(DRAIN_CYC - 1)) state_d = ST_IDLE;
          else                                drn_d   = drn_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drn_q   <= '0;
      pat_q   <= PAT_DET;
      w10_q   <= 1'b0;
      en_q    <= 1'b0;
      cfg_q   <= '{pat: PAT_DET, sym10: 1'b0};
    end else begin
      state_q <= state_d;
      drn_q   <= drn_d;
      pat_q   <= pat_d;
      w10_q   <= w10_d;
      en_q    <= en_d;
      cfg_q   <= cfg_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign stopping = (state_q == ST_FLUSH) || (state_q == ST_DRAIN);
  assign gen_en   = (state_q == ST_RUN);
  assign flush    = (state_q == ST_FLUSH);
  assign cnt_clr  = start_ok;
  assign run_cfg  = cfg_q;
  assign seed_cfg = cfg_d;
  assign ctrl_rd  = {busy, stopping, en_q, w10_q, pat_q, 10'b0};

endmodule

// File: rtl/lbist_txgen.sv
module lbist_txgen
  import lbist_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 8,
  parameter int CNT_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gen_en,
  input  logic                  flush,
  input  logic                  cnt_clr,
  input  run_cfg_t              run_cfg,
  input  run_cfg_t              seed_cfg,
  output logic                  tx_vld,
  output logic                  tx_last,
  output sym_t [LANES-1:0]      tx_sym,
  output logic                  tx_idle,
  output logic [CNT_W-1:0]      tx_cnt
);

  localparam int POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

  logic [POS_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vld_q, vld_d, last_q, last_d;
  logic             active, at_end;

  assign active = gen_en || (flush && (pos_q != '0));
  assign at_end = (pos_q == POS_W'(FRAME_LEN - 1));

  always_comb begin
    pos_d  = pos_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    last_d = 1'b0;
    if (cnt_clr) begin
      pos_d = '0;
      cnt_d = '0;
    end else if (active) begin
      vld_d  = 1'b1;
      last_d = at_end;
      pos_d  = at_end ? '0 : pos_q + 1'b1;
      if (at_end && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      last_q <= last_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sym_t  st_q, st_d, sym_q, sym_d;
    step_t nx;

    always_comb begin
      nx    = pat_step(run_cfg.pat, run_cfg.sym10, st_q);
      st_d  = st_q;
      sym_d = sym_q;
      if (cnt_clr) begin
        st_d = pat_seed(seed_cfg.pat, l);
      end else if (active) begin
        st_d  = nx.st;
        sym_d = nx.sym;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= '0;
        sym_q <= '0;
      end else begin
        st_q  <= st_d;
        sym_q <= sym_d;
      end
    end

    assign tx_sym[l] = sym_q;
  end

  assign tx_vld  = vld_q;
  assign tx_last = last_q;
  assign tx_idle = (pos_q == '0);
  assign tx_cnt  = cnt_q;

endmodule

// File: rtl/lbist_lpbk.sv
module lbist_lpbk
  import lbist_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LAT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_last,
  input  sym_t [LANES-1:0] in_sym,
  input  logic [LANES-1:0] flip,
  output logic             out_vld,
  output logic             out_last,
  output sym_t [LANES-1:0] out_sym
);

  logic [LAT-1:0]             v_q, l_q;
  sym_t [LAT-1:0][LANES-1:0]  s_q;
  sym_t [LANES-1:0]           s_in;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      s_in[k] = in_sym[k] ^ {{(SYM_W-1){1'b0}}, flip[k] & in_vld};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      l_q <= '0;
      s_q <= '0;
    end else begin
      v_q[0] <= in_vld;
      l_q[0] <= in_last;
      s_q[0] <= s_in;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        l_q[i] <= l_q[i-1];
        s_q[i] <= s_q[i-1];
      end
    end
  end

  assign out_vld  = v_q[LAT-1];
  assign out_last = l_q[LAT-1];
  assign out_sym  = s_q[LAT-1];

endmodule

// File: rtl/lbist_lane_chk.sv
module lbist_lane_chk
  import lbist_pkg::*;
#(
  parameter int LANE  = 0,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             cnt_clr,
  input  run_cfg_t         run_cfg,
  input  run_cfg_t         seed_cfg,
  input  logic             rx_vld,
  input  logic             rx_last,
  input  sym_t             rx_sym,
  output logic [CNT_W-1:0] rx_cnt,
  output logic [CNT_W-1:0] err_cnt
);

  sym_t             ref_q, ref_d;
  logic             bad_q, bad_d;
  logic [CNT_W-1:0] rxc_q, rxc_d, erc_q, erc_d;
  step_t            nx;
  logic             miss, take;

  always_comb begin
    nx    = pat_step(run_cfg.pat, run_cfg.sym10, ref_q);
    miss  = (rx_sym != nx.sym);
    take  = rx_en && rx_vld;
    ref_d = ref_q;
    bad_d = bad_q;
    rxc_d = rxc_q;
    erc_d = erc_q;
    if (cnt_clr) begin
      ref_d = pat_seed(seed_cfg.pat, LANE);
      bad_d = 1'b0;
      rxc_d = '0;
      erc_d = '0;
    end else if (take) begin
      ref_d = nx.st;
      if (rx_last) begin
        bad_d = 1'b0;
        if (rxc_q != '1) rxc_d = rxc_q + 1'b1;
        if ((bad_q || miss) && (erc_q != '1)) erc_d = erc_q + 1'b1;
      end else begin
        bad_d = bad_q || miss;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      bad_q <= 1'b0;
      rxc_q <= '0;
      erc_q <= '0;
    end else begin
      ref_q <= ref_d;
      bad_q <= bad_d;
      rxc_q <= rxc_d;
      erc_q <= erc_d;
    end
  end

  assign rx_cnt  = rxc_q;
  assign err_cnt = erc_q;

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
  import lbist_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 16,
  parameter int FRAME_LEN = 8,
  parameter int LAT       = 4,
  parameter int DRAIN_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [LANES-1:0]  lpbk_flip
);

  localparam int RX_BASE  = 2;
  localparam int ERR_BASE = RX_BASE + LANES;

  logic [15:0]      ctrl_rd;
  run_cfg_t         run_cfg, seed_cfg;
  logic             gen_en, flush, cnt_clr, busy, stopping, tx_idle;
  logic             tx_vld, tx_last, rx_vld, rx_last;
  sym_t [LANES-1:0] tx_sym, rx_sym;
  logic [CNT_W-1:0] tx_cnt;
  logic [LANES-1:0][CNT_W-1:0] rx_cnt, err_cnt;

  lbist_ctrl #(.ADDR_W(ADDR_W), .DRAIN_CYC(DRAIN_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_idle(tx_idle), .ctrl_rd(ctrl_rd),
    .run_cfg(run_cfg), .seed_cfg(seed_cfg), .gen_en(gen_en), .flush(flush),
    .cnt_clr(cnt_clr), .busy(busy), .stopping(stopping)
  );

  lbist_txgen #(.LANES(LANES), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_txgen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .flush(flush), .cnt_clr(cnt_clr),
    .run_cfg(run_cfg), .seed_cfg(seed_cfg), .tx_vld(tx_vld), .tx_last(tx_last),
    .tx_sym(tx_sym), .tx_idle(tx_idle), .tx_cnt(tx_cnt)
  );

  lbist_lpbk #(.LANES(LANES), .LAT(LAT)) u_lpbk (
    .clk(clk), .rst_n(rst_n), .in_vld(tx_vld), .in_last(tx_last), .in_sym(tx_sym),
    .flip(lpbk_flip), .out_vld(rx_vld), .out_last(rx_last), .out_sym(rx_sym)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    lbist_lane_chk #(.LANE(l), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .rx_en(busy), .cnt_clr(cnt_clr),
      .run_cfg(run_cfg), .seed_cfg(seed_cfg), .rx_vld(rx_vld), .rx_last(rx_last),
      .rx_sym(rx_sym[l]), .rx_cnt(rx_cnt[l]), .err_cnt(err_cnt[l])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(0)) reg_rdata = ctrl_rd;
    if (reg_addr == ADDR_W'(1)) reg_rdata = 16'(tx_cnt);
    for (int k = 0; k < LANES; k++) begin
      if (reg_addr == ADDR_W'(RX_BASE + k))  reg_rdata = 16'(rx_cnt[k]);
      if (reg_addr == ADDR_W'(ERR_BASE + k)) reg_rdata = 16'(err_cnt[k]);
    end
  end

endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              busy,
  input logic              stopping,
  input logic [CNT_W-1:0]  tx_cnt
);

  logic ctl_wr;
  assign ctl_wr = reg_wr && (reg_addr == '0);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[15] && reg_wdata[13] && !busy) |=> (busy && tx_cnt == '0));

  // R4
  disable_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[13]) |=> !busy);

  // R3
  stop_within_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopping |-> busy);

  // R3
  end_follows_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(stopping) || $past(ctl_wr && !reg_wdata[13])));

  // R8
  tx_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_cnt == '1) |=> (tx_cnt == '1));

  // R9
  idle_stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_wr && reg_wdata[14] && !reg_wdata[15]) |=> !stopping);

endmodule

bind lbist_engine lbist_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .stopping(stopping), .tx_cnt(tx_cnt)
);

// File: tb/test_lbist_engine.sv
module test_lbist_engine;

  localparam int LANES     = 4;
  localparam int CNT_W     = 6;
  localparam int DRAIN_CYC = 8;
  localparam logic [15:0] EN    = 16'h2000;
  localparam logic [15:0] START = 16'h8000;
  localparam logic [15:0] STOP  = 16'h4000;

  logic             clk, rst_n, reg_wr;
  logic [3:0]       reg_addr;
  logic [15:0]      reg_wdata, reg_rdata;
  logic [LANES-1:0] lpbk_flip;

  int errs;
  int checks;
  bit done;

  lbist_engine #(.LANES(LANES), .ADDR_W(4), .CNT_W(CNT_W), .FRAME_LEN(8),
                 .LAT(4), .DRAIN_CYC(DRAIN_CYC)) i_lbist_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lpbk_flip(lpbk_flip)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(4'd0, v); chk("R1 reset control", v, 16'h0000);
    for (int a = 1; a < 10; a++) begin
      rd(4'(a), v); chk("R5 reset counter", v, 16'h0000);
    end
  endtask

  task automatic t_fields();
    logic [15:0] v;
    wr(4'd0, 16'h3F3F);
    rd(4'd0, v); chk("R1 field readback", v, 16'h3C00);
    wr(4'd0, EN | STOP);
    rd(4'd0, v); chk("R9 stop while idle", v, 16'h2000);
    wr(4'd0, START);
    rd(4'd0, v); chk("R2 start without enable", v, 16'h0000);
    repeat (30) @(negedge clk);
    rd(4'd1, v); chk("R2 no frames without enable", v, 16'h0000);
  endtask

  task automatic t_run(input logic [1:0] pat, input logic w10, input logic [LANES-1:0] flip,
                       input int ncyc, output logic [15:0] txc);
    logic [15:0] cfg, v, rx, er;
    int n;
    cfg = {3'b000, w10, pat, 10'b0};
    lpbk_flip = flip;
    wr(4'd0, cfg | EN);
    wr(4'd0, cfg | EN | START);
    rd(4'd0, v); chk("R2 start reads set", v, cfg | EN | START);
    rd(4'd1, v); chk("R2 counter cleared at start", v, 16'h0000);
    repeat (ncyc) @(negedge clk);
    wr(4'd0, cfg | EN | STOP);
    n = 0;
    rd(4'd0, v);
    while (v[14] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(4'd0, v);
    end
    chk("R3 stop holds for drain", 16'(n >= DRAIN_CYC), 16'h0001);
    chk("R3 control after stop", v, cfg | EN);
    rd(4'd1, txc);
    chk("R6 frames sent", 16'(txc != 0), 16'h0001);
    for (int l = 0; l < LANES; l++) begin
      rd(4'(2 + l), rx);
      rd(4'(2 + LANES + l), er);
      chk("R6 received equals sent", rx, txc);
      if (flip[l]) chk("R7 corrupted lane all errored", er, txc);
      else         chk("R6 R7 clean lane no errors", er, 16'h0000);
    end
    lpbk_flip = '0;
  endtask

  task automatic t_saturate();
    logic [15:0] txc, v;
    t_run(2'd3, 1'b1, 4'b0001, 700, txc);
    chk("R8 tx saturates", txc, 16'd63);
    rd(4'd6, v); chk("R8 error count saturates", v, 16'd63);
  endtask

  task automatic t_abort();
    logic [15:0] v, a;
    wr(4'd0, 16'h0C00 | EN);
    wr(4'd0, 16'h0C00 | EN | START);
    repeat (40) @(negedge clk);
    wr(4'd0, 16'h0000);
    rd(4'd0, v); chk("R4 disable clears start", v, 16'h0000);
    rd(4'd1, a);
    repeat (40) @(negedge clk);
    rd(4'd1, v); chk("R4 tx count frozen", v, a);
    rd(4'd12, v); chk("R5 unmapped address", v, 16'h0000);
    rd(4'd10, v); chk("R5 unmapped address", v, 16'h0000);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] t;
    errs = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; lpbk_flip = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_run(2'd3, 1'b1, 4'b0000, 100, t);
    t_run(2'd3, 1'b0, 4'b0100, 100, t);
    t_run(2'd0, 1'b1, 4'b0000, 60, t);
    t_run(2'd1, 1'b0, 4'b0000, 60, t);
    t_run(2'd2, 1'b1, 4'b1000, 60, t);
    t_saturate();
    t_abort();
    t_run(2'd3, 1'b0, 4'b0000, 80, t);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule